// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block drives the control side of a parallel RGB panel with no frame memory of its own. A pixel-clock enable advances a horizontal position counter. Each completed line advances a vertical line counter. The two counters produce horizontal sync, vertical sync, a data-enable strobe and a blanking flag, built from a programmed active size, front porch, sync width and back porch on each axis. Every frame also gives three things to the rest of the display path:

- a one-cycle pulse that tells the frame fetch engine to start;
- a frame-done status bit with a maskable interrupt;
- the byte address of the first pixel to show, worked out from a base address, a virtual line width, the bytes per pixel and a pan offset.

Software writes its settings through a simple word-addressed register port. The timing geometry and the start address are copied into shadow state only at the frame wrap. While the output is switched off, they are copied on every cycle. As a result a frame never changes shape partway through. A geometry whose total on either axis exceeds 2048 is never copied, and the previous timing stays in force.

Top module: `lcd_timing_gen`

## Requirements
- R1: `de_o` is high only when the horizontal position is below the active pixel count, the line is below the active line count, output is enabled and forced blanking is off. `blank_o` is always the inverse of `de_o`. Active counts sit at address 0: lines in bits 31:16, pixels in bits 15:0.
- R2: Each line runs through the active pixels, then the front porch, then the sync pulse, then the back porch. The line length is the sum of these four parts. Address 1 holds the back porch in bits 31:16 and the front porch in bits 15:0. Address 3 bits 15:0 hold the horizontal sync width.
- R3: Each frame runs through the active lines, the front porch lines, the sync lines and the back porch lines in that order. Address 2 holds the back porch in bits 31:16 and the front porch in bits 15:0. Address 3 bits 31:16 hold the vertical sync width.
- R4: Control register (address 4) bit 2 makes horizontal sync active low, and bit 3 does the same for vertical sync. While output is disabled, both syncs rest at their inactive level.
- R5: `dma_start_o` is a one-cycle pulse on the leading edge of vertical sync. That edge is falling when bit 3 is set and rising otherwise, so the pulse falls in the first cycle of the first sync line.
- R6: A value of 7 in control bits 31:28 forces blanking. `de_o` stays low while both syncs keep running.
- R7: While running, a new geometry takes effect only at the frame wrap, which is the clock edge that leaves the last position of the last line. Until then the frame in progress keeps its old timing.
- R8: A geometry is rejected, and the previous one kept, if either axis total exceeds 2048 or either active count or sync width is zero. A total of exactly 2048 is accepted.
- R9: The frame-done status bit (address 8, bit 0) is set after the last active pixel of the last active line. A write to address 8 with bit 0 at zero clears it, and a write with bit 0 at one leaves it unchanged. `irq_o` equals the status bit ANDed with the interrupt enable (address 9, bit 0).
- R10: `gfx_addr_o` equals base (address 6) plus (pan y × virtual width + pan x) × bytes per pixel. Pan y is address 5 bits 31:16 and pan x is bits 15:0. Virtual width is address 7 bits 15:0 and bytes per pixel is bits 18:16. The address is refreshed at the same points as the geometry in R7.
- R11: Control bit 0 enables output. While it is clear, both counters are held at zero. In the first cycle after it is set, the position is the first active pixel. Control bit 1 appears on `pclk_inv_o`.
- R12: The counters advance only on clock edges where `pix_ce` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pix_ce | input | 1 | Pixel clock enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 2 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 3 |
| de_o | output | 1 | Data enable |
| blank_o | output | 1 | Blanking flag |
| pclk_inv_o | output | 1 | Pixel clock inversion select |
| dma_start_o | output | 1 | Frame fetch start pulse |
| irq_o | output | 1 | Frame-done interrupt |
| gfx_addr_o | output | 32 | Byte address of the first displayed pixel |

## Verification
A cycle-by-cycle model in the bench tracks every sync, enable and start pulse across whole frames, including runs where the pixel enable is high only one clock in three. It therefore exposes porches placed on the wrong side of the sync pulse, sync widths that are off by one, and start pulses fired on the trailing edge instead of the leading one. Geometry is also rewritten in the middle of a frame. A design that applies the new values at once would tear the frame in progress. Totals of 2049 and of exactly 2048 are written to expose a cap that is off by one, and the frame-done bit is written back with ones and then with a zero to catch a design that clears on the wrong value.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int FW = 16;
  localparam int SW = FW + 2;

  typedef struct packed {
    logic [FW-1:0] act;
    logic [FW-1:0] fp;
    logic [FW-1:0] sw;
    logic [FW-1:0] bp;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t h;
    axis_cfg_t v;
  } timing_cfg_t;

  typedef enum logic [3:0] {
    A_ACTIVE = 4'd0,
    A_HPORCH = 4'd1,
    A_VPORCH = 4'd2,
    A_SYNCW  = 4'd3,
    A_CTRL   = 4'd4,
    A_PAN    = 4'd5,
    A_BASE   = 4'd6,
    A_GEOM   = 4'd7,
    A_STAT   = 4'd8,
    A_IRQEN  = 4'd9
  } reg_addr_e;

  localparam logic [3:0] MODE_BLANK = 4'h7;

  function automatic logic [SW-1:0] axis_total(axis_cfg_t c);
    return SW'(c.act) + SW'(c.fp) + SW'(c.sw) + SW'(c.bp);
  endfunction

  function automatic logic axis_ok(axis_cfg_t c, logic [31:0] cap);
    return (c.act != '0) && (c.sw != '0) && (32'(axis_total(c)) <= cap);
  endfunction

  function automatic logic [31:0] first_pixel_addr(logic [31:0] base,
                                                   logic [FW-1:0] xo,
                                                   logic [FW-1:0] yo,
                                                   logic [FW-1:0] vw,
                                                   logic [2:0] bpp);
    logic [31:0] pix;
    pix = 32'(yo) * 32'(vw) + 32'(xo);
    return base + pix * 32'(bpp);
  endfunction
endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      step,
  input  axis_cfg_t cfg,
  output logic      last,
  output logic      act_last,
  output logic      active,
  output logic      sync
);
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] pos, tot, s_beg, s_end;

  assign pos   = SW'(cnt_q);
  assign tot   = axis_total(cfg);
  assign s_beg = SW'(cfg.act) + SW'(cfg.fp);
  assign s_end = s_beg + SW'(cfg.sw);

  assign last     = (pos == tot - SW'(1));
  assign act_last = (pos == SW'(cfg.act) - SW'(1));
  assign active   = (pos < SW'(cfg.act));
  assign sync     = (pos >= s_beg) && (pos < s_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (step)   cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter timing_cfg_t DEF_CFG = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [3:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          frame_done,
  output timing_cfg_t   cfg_live,
  output logic          run,
  output logic          hs_low,
  output logic          vs_low,
  output logic          pclk_inv,
  output logic [3:0]    mode,
  output logic [31:0]   base,
  output logic [FW-1:0] pan_x,
  output logic [FW-1:0] pan_y,
  output logic [FW-1:0] vwidth,
  output logic [2:0]    bpp,
  output logic          irq_en,
  output logic          stat
);
  logic [3:0] ctl_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_live <= DEF_CFG;
      ctl_lo   <= '0;
      mode     <= '0;
      base     <= '0;
      pan_x    <= '0;
      pan_y    <= '0;
      vwidth   <= '0;
      bpp      <= '0;
      irq_en   <= 1'b0;
    end else if (wr) begin
      case (addr)
        A_ACTIVE: begin cfg_live.v.act <= wdata[31:16]; cfg_live.h.act <= wdata[15:0]; end
        A_HPORCH: begin cfg_live.h.bp  <= wdata[31:16]; cfg_live.h.fp  <= wdata[15:0]; end
        A_VPORCH: begin cfg_live.v.bp  <= wdata[31:16]; cfg_live.v.fp  <= wdata[15:0]; end
        A_SYNCW:  begin cfg_live.v.sw  <= wdata[31:16]; cfg_live.h.sw  <= wdata[15:0]; end
        A_CTRL:   begin mode <= wdata[31:28]; ctl_lo <= wdata[3:0]; end
        A_PAN:    begin pan_y <= wdata[31:16]; pan_x <= wdata[15:0]; end
        A_BASE:   base <= wdata;
        A_GEOM:   begin bpp <= wdata[18:16]; vwidth <= wdata[15:0]; end
        A_IRQEN:  irq_en <= wdata[0];
        default:  ;
      endcase
    end
  end

  // Status: a frame-done event wins over a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          stat <= 1'b0;
    else if (frame_done)                 stat <= 1'b1;
    else if (wr && (addr == A_STAT))     stat <= stat & wdata[0];
  end

  assign run      = ctl_lo[0];
  assign pclk_inv = ctl_lo[1];
  assign hs_low   = ctl_lo[2];
  assign vs_low   = ctl_lo[3];

  always_comb begin
    rdata = '0;
    case (addr)
      A_ACTIVE: rdata = {cfg_live.v.act, cfg_live.h.act};
      A_HPORCH: rdata = {cfg_live.h.bp, cfg_live.h.fp};
      A_VPORCH: rdata = {cfg_live.v.bp, cfg_live.v.fp};
      A_SYNCW:  rdata = {cfg_live.v.sw, cfg_live.h.sw};
      A_CTRL:   rdata = {mode, 24'd0, ctl_lo};
      A_PAN:    rdata = {pan_y, pan_x};
      A_BASE:   rdata = base;
      A_GEOM:   rdata = {13'd0, bpp, vwidth};
      A_STAT:   rdata = {31'd0, stat};
      A_IRQEN:  rdata = {31'd0, irq_en};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/lcd_tg_shadow.sv
module lcd_tg_shadow
  import lcd_tg_pkg::*;
#(
  parameter int          MAX_TOTAL = 2048,
  parameter timing_cfg_t DEF_CFG   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  timing_cfg_t   cfg_live,
  input  logic [31:0]   base,
  input  logic [FW-1:0] pan_x,
  input  logic [FW-1:0] pan_y,
  input  logic [FW-1:0] vwidth,
  input  logic [2:0]    bpp,
  output timing_cfg_t   cfg_s,
  output logic [31:0]   addr_s,
  output logic          live_ok
);
  localparam logic [31:0] CAP = 32'(MAX_TOTAL);

  assign live_ok = axis_ok(cfg_live.h, CAP) && axis_ok(cfg_live.v, CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_s  <= DEF_CFG;
      addr_s <= '0;
    end else if (load) begin
      if (live_ok) cfg_s <= cfg_live;
      addr_s <= first_pixel_addr(base, pan_x, pan_y, vwidth, bpp);
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int MAX_TOTAL = 2048,
  parameter int DEF_HACT  = 4,
  parameter int DEF_HFP   = 1,
  parameter int DEF_HSW   = 1,
  parameter int DEF_HBP   = 2,
  parameter int DEF_VACT  = 3,
  parameter int DEF_VFP   = 1,
  parameter int DEF_VSW   = 1,
  parameter int DEF_VBP   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_ce,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o,
  output logic        blank_o,
  output logic        pclk_inv_o,
  output logic        dma_start_o,
  output logic        irq_o,
  output logic [31:0] gfx_addr_o
);
  localparam int CW = $clog2(MAX_TOTAL);
  localparam timing_cfg_t DEF_CFG = '{
    h: '{act: FW'(DEF_HACT), fp: FW'(DEF_HFP), sw: FW'(DEF_HSW), bp: FW'(DEF_HBP)},
    v: '{act: FW'(DEF_VACT), fp: FW'(DEF_VFP), sw: FW'(DEF_VSW), bp: FW'(DEF_VBP)}
  };

  timing_cfg_t   cfg_live, cfg_s;
  logic          run, hs_low, vs_low, pclk_inv, irq_en, stat;
  logic [3:0]    mode;
  logic [31:0]   base;
  logic [FW-1:0] pan_x, pan_y, vwidth;
  logic [2:0]    bpp;
  logic          live_ok;

  // Named internal events
  logic frame_wrap, shadow_load, frame_done_ev, force_blank;
  logic vs_q, vsync_lead;

  axis_cfg_t cfg_a  [2];
  logic      step_a [2];
  logic      last_a [2];
  logic      al_a   [2];
  logic      act_a  [2];
  logic      sync_a [2];

  lcd_tg_regs #(.DEF_CFG(DEF_CFG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .frame_done(frame_done_ev), .cfg_live(cfg_live),
    .run(run), .hs_low(hs_low), .vs_low(vs_low), .pclk_inv(pclk_inv),
    .mode(mode), .base(base), .pan_x(pan_x), .pan_y(pan_y), .vwidth(vwidth),
    .bpp(bpp), .irq_en(irq_en), .stat(stat)
  );

  lcd_tg_shadow #(.MAX_TOTAL(MAX_TOTAL), .DEF_CFG(DEF_CFG)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(shadow_load), .cfg_live(cfg_live),
    .base(base), .pan_x(pan_x), .pan_y(pan_y), .vwidth(vwidth), .bpp(bpp),
    .cfg_s(cfg_s), .addr_s(gfx_addr_o), .live_ok(live_ok)
  );

  assign cfg_a[0]  = cfg_s.h;
  assign cfg_a[1]  = cfg_s.v;
  assign step_a[0] = pix_ce;
  assign step_a[1] = pix_ce & last_a[0];

  for (genvar g = 0; g < 2; g++) begin : g_axis
    lcd_tg_axis #(.CW(CW)) u_axis (
      .clk(clk), .rst_n(rst_n), .run(run), .step(step_a[g]), .cfg(cfg_a[g]),
      .last(last_a[g]), .act_last(al_a[g]), .active(act_a[g]), .sync(sync_a[g])
    );
  end

  assign frame_wrap    = run & pix_ce & last_a[0] & last_a[1];
  assign shadow_load   = ~run | frame_wrap;
  assign frame_done_ev = run & pix_ce & al_a[0] & al_a[1];
  assign force_blank   = (mode == MODE_BLANK);

  assign hsync_o    = (run & sync_a[0]) ^ hs_low;
  assign vsync_o    = (run & sync_a[1]) ^ vs_low;
  assign de_o       = run & act_a[0] & act_a[1] & ~force_blank;
  assign blank_o    = ~de_o;
  assign pclk_inv_o = pclk_inv;
  assign irq_o      = stat & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vsync_o;
  end

  assign vsync_lead  = vs_low ? (vs_q & ~vsync_o) : (~vs_q & vsync_o);
  assign dma_start_o = vsync_lead;
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_axis_chk
  import lcd_tg_pkg::*;
#(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [CW-1:0] cnt,
  input logic [SW-1:0] tot
);
  // R2 for the horizontal instance, R3 for the vertical one
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (SW'(cnt) < tot));

  assert_idle_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

module lcd_tg_chk
  import lcd_tg_pkg::*;
#(
  parameter int MAX_TOTAL = 2048
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        shadow_load,
  input logic        frame_done_ev,
  input logic        force_blank,
  input timing_cfg_t cfg_s,
  input logic        de_o,
  input logic        dma_start_o,
  input logic        vsync_o,
  input logic        vs_low,
  input logic        stat
);
  assert_dma_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start_o |-> (vsync_o == !vs_low));

  assert_blank_no_de_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_blank |-> !de_o);

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !shadow_load) |=> $stable(cfg_s));

  assert_total_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(axis_total(cfg_s.h)) <= 32'(MAX_TOTAL)) &&
    (32'(axis_total(cfg_s.v)) <= 32'(MAX_TOTAL)));

  assert_done_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_ev |=> stat);
endmodule

bind lcd_tg_axis lcd_tg_axis_chk #(.CW(CW)) ax_chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt_q), .tot(tot)
);

bind lcd_timing_gen lcd_tg_chk #(.MAX_TOTAL(MAX_TOTAL)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .shadow_load(shadow_load),
  .frame_done_ev(frame_done_ev), .force_blank(force_blank), .cfg_s(cfg_s),
  .de_o(de_o), .dma_start_o(dma_start_o), .vsync_o(vsync_o),
  .vs_low(vs_low), .stat(stat)
);

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_ce = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic hsync_o, vsync_o, de_o, blank_o, pclk_inv_o, dma_start_o, irq_o;
  logic [31:0] gfx_addr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model: 0 ha 1 hf 2 hs 3 hb 4 va 5 vf 6 vs 7 vb
  int s[8];
  int l[8];
  int mh, mv, g_k;
  bit fresh, g_polh, g_polv, g_blank;

  lcd_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .blank_o(blank_o),
    .pclk_inv_o(pclk_inv_o), .dma_start_o(dma_start_o), .irq_o(irq_o),
    .gfx_addr_o(gfx_addr_o)
  );

  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_timing(int ha, int hf, int hs, int hb, int va, int vf, int vs, int vb);
    wr(4'd0, {16'(va), 16'(ha)});
    wr(4'd1, {16'(hb), 16'(hf)});
    wr(4'd2, {16'(vb), 16'(vf)});
    wr(4'd3, {16'(vs), 16'(hs)});
    l = '{ha, hf, hs, hb, va, vf, vs, vb};
  endtask

  function automatic bit live_ok();
    int ht = l[0] + l[1] + l[2] + l[3];
    int vt = l[4] + l[5] + l[6] + l[7];
    return !(l[0] == 0 || l[2] == 0 || l[4] == 0 || l[6] == 0 || ht > 2048 || vt > 2048);
  endfunction

  task automatic model_step();
    mh++;
    if (mh == s[0] + s[1] + s[2] + s[3]) begin
      mh = 0;
      mv++;
      if (mv == s[4] + s[5] + s[6] + s[7]) begin
        mv = 0;
        if (live_ok()) s = l;
      end
    end
  endtask

  task automatic align(int div);
    bit seen = 0;
    int guard = 0;
    while (!seen && guard < 40000) begin
      @(negedge clk);
      seen = dma_start_o;
      if (!seen) begin pix_ce = ((g_k % div) == 0); g_k++; end
      guard++;
    end
    mh = 0; mv = s[4] + s[5]; fresh = 1;
  endtask

  // Compare every cycle against the model for n cycles (R1 R2 R3 R4 R5 R12)
  task automatic check_cycles(int n, int div, string req);
    int e_hs = 0, e_vs = 0, e_de = 0, e_dma = 0;
    for (int i = 0; i < n; i++) begin
      bit hsx, vsx, dex, dmx, ce;
      if (i > 0) @(negedge clk);
      hsx = ((mh >= s[0] + s[1]) && (mh < s[0] + s[1] + s[2])) ^ g_polh;
      vsx = ((mv >= s[4] + s[5]) && (mv < s[4] + s[5] + s[6])) ^ g_polv;
      dex = (mh < s[0]) && (mv < s[4]) && !g_blank;
      dmx = fresh && (mh == 0) && (mv == s[4] + s[5]);
      if (hsync_o !== hsx) begin if (e_hs == 0) $display("  first hsync miss h=%0d v=%0d", mh, mv); e_hs++; end
      if (vsync_o !== vsx) begin if (e_vs == 0) $display("  first vsync miss h=%0d v=%0d", mh, mv); e_vs++; end
      if (de_o !== dex || blank_o !== !dex) begin if (e_de == 0) $display("  first de miss h=%0d v=%0d", mh, mv); e_de++; end
      if (dma_start_o !== dmx) begin if (e_dma == 0) $display("  first dma miss h=%0d v=%0d", mh, mv); e_dma++; end
      ce = ((g_k % div) == 0); g_k++;
      pix_ce = ce;
      fresh = ce;
      if (ce) model_step();
    end
    chk(e_hs == 0, req, "hsync mismatches", e_hs, 0);
    chk(e_vs == 0, req, "vsync mismatches", e_vs, 0);
    chk(e_de == 0, req, "de/blank mismatches", e_de, 0);
    chk(e_dma == 0, req, "dma start mismatches", e_dma, 0);
    pix_ce = 1'b1;
  endtask

  task automatic t_reset();
    chk(de_o == 0 && blank_o == 1, "R11", "de/blank at reset", {de_o, blank_o}, 2'b01);
    chk(hsync_o == 0 && vsync_o == 0, "R4", "syncs idle at reset", {hsync_o, vsync_o}, 0);
    chk(dma_start_o == 0 && irq_o == 0, "R9", "dma/irq at reset", {dma_start_o, irq_o}, 0);
    chk(gfx_addr_o == 0, "R10", "addr at reset", gfx_addr_o, 0);
  endtask

  task automatic t_basic();
    set_timing(5, 2, 3, 2, 4, 1, 2, 1);
    s = l;
    wr(4'd4, 32'h1);
    align(1);
    check_cycles(3 * 96, 1, "R1 R2 R3 R5 basic");
  endtask

  task automatic t_ce_div();
    align(3);
    check_cycles(2 * 96 * 3, 3, "R12 ce gating");
  endtask

  task automatic t_enable_origin();
    wr(4'd4, 32'h0);
    chk(de_o == 0 && hsync_o == 0 && vsync_o == 0, "R11", "outputs while disabled",
        {de_o, hsync_o, vsync_o}, 0);
    wr(4'd4, 32'h1);
    chk(de_o == 1, "R11", "first active pixel after enable", de_o, 1);
  endtask

  task automatic t_polarity();
    wr(4'd4, 32'h0);
    wr(4'd4, 32'hC);
    chk(hsync_o == 1 && vsync_o == 1, "R4", "active-low idle levels", {hsync_o, vsync_o}, 2'b11);
    wr(4'd4, 32'hD);
    g_polh = 1; g_polv = 1;
    align(1);
    check_cycles(2 * 96, 1, "R4 R5 active low");
    wr(4'd4, 32'h0);
    wr(4'd4, 32'h1);
    g_polh = 0; g_polv = 0;
  endtask

  task automatic t_blank_pclk();
    wr(4'd4, 32'h7000_0001);
    g_blank = 1;
    align(1);
    check_cycles(2 * 96, 1, "R6 forced blank");
    g_blank = 0;
    wr(4'd4, 32'h3);
    chk(pclk_inv_o == 1, "R11", "pixel clock invert", pclk_inv_o, 1);
    wr(4'd4, 32'h1);
    chk(pclk_inv_o == 0, "R11", "pixel clock normal", pclk_inv_o, 0);
  endtask

  task automatic t_shadow();
    align(1);
    fork
      check_cycles(4 * 96, 1, "R7 mid-frame update");
      begin
        repeat (2) @(negedge clk);
        set_timing(6, 1, 2, 3, 3, 2, 1, 2);
      end
    join
  endtask

  task automatic t_reject();
    align(1);
    fork
      check_cycles(2 * 96, 1, "R8 total 2049 rejected");
      begin
        repeat (2) @(negedge clk);
        set_timing(2040, 2, 3, 4, 1, 1, 1, 1);
      end
    join
    align(1);
    fork
      check_cycles(96 + 2 * 8192, 1, "R8 total 2048 accepted");
      begin
        repeat (2) @(negedge clk);
        set_timing(2040, 2, 3, 3, 1, 1, 1, 1);
      end
    join
    wr(4'd4, 32'h0);
    set_timing(5, 2, 3, 2, 4, 1, 2, 1);
    s = l;
    wr(4'd4, 32'h1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    int guard = 0;
    wr(4'd9, 32'h1);
    wr(4'd8, 32'h0);
    while (!irq_o && guard < 400) begin @(negedge clk); guard++; end
    chk(irq_o == 1, "R9", "irq after frame done", irq_o, 1);
    rd(4'd8, d);
    chk(d[0] == 1, "R9", "status set", d, 1);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, d);
    chk(d[0] == 1, "R9", "write with ones keeps status", d, 1);
    wr(4'd9, 32'h0);
    chk(irq_o == 0, "R9", "irq masked", irq_o, 0);
    wr(4'd9, 32'h1);
    chk(irq_o == 1, "R9", "irq unmasked", irq_o, 1);
    wr(4'd8, 32'hFFFF_FFFE);
    rd(4'd8, d);
    chk(d[0] == 0 && irq_o == 0, "R9", "write zero clears", {d[0], irq_o}, 0);
  endtask

  task automatic t_addr();
    logic [31:0] exp1, exp2;
    exp1 = 32'h1000_0000 + 32'((2 * 800 + 3) * 4);
    align(1);
    wr(4'd6, 32'h1000_0000);
    wr(4'd7, {13'd0, 3'd4, 16'd800});
    wr(4'd5, {16'd2, 16'd3});
    chk(gfx_addr_o == 0, "R10", "address held mid-frame", gfx_addr_o, 0);
    align(1);
    chk(gfx_addr_o == exp1, "R10", "address after wrap", gfx_addr_o, exp1);
    wr(4'd4, 32'h0);
    wr(4'd7, {13'd0, 3'd3, 16'd10});
    wr(4'd5, {16'd1, 16'd0});
    @(negedge clk);
    exp2 = 32'h1000_0000 + 32'(1 * 10 * 3);
    chk(gfx_addr_o == exp2, "R10", "address while disabled", gfx_addr_o, exp2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    g_k = 0; g_polh = 0; g_polv = 0; g_blank = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ce_div();
    t_enable_origin();
    t_polarity();
    t_blank_pclk();
    t_shadow();
    t_reject();
    t_irq();
    t_addr();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule